// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Port

This block sits on a simple single-cycle processor bus and offers two 32-bit word registers in the top 256-byte peripheral window of the address space. A store to the transmit register hands the low byte of the store data to a character sink, marked by a one-cycle valid strobe. Keystrokes come in as a byte with a valid pulse. Each one is latched into the receive register and raises a one-cycle interrupt request for the interrupt controller to record as pending.

There is no receive buffering and no echo. A new keystroke replaces an unread one, and the transmit stream only carries characters that were written by software. Addresses in the window that match neither register return zero on reads and ignore writes. Addresses outside the window are not decoded by this block.

Top module: `term_port`

## Requirements
- R1: After reset, `chr_valid` and `kbd_irq` are low, and a read of the receive register (byte address 0xFFFFFF04) returns 0.
- R2: A write to any byte address from 0xFFFFFF00 to 0xFFFFFF03 asserts `chr_valid` for exactly one cycle, in the cycle that follows the write edge. In that cycle `chr_data` equals bits 7:0 of the write data.
- R3: Bits 31:8 of the write data have no effect on the emitted character.
- R4: A `key_valid` pulse stores `key_code` into the receive register. A read from 0xFFFFFF04 to 0xFFFFFF07 then returns that code zero-extended to 32 bits, starting in the cycle after the pulse.
- R5: Each `key_valid` pulse raises `kbd_irq` for exactly one cycle, in the cycle after the pulse. Back-to-back pulses give one irq cycle each.
- R6: A keystroke never asserts `chr_valid` (no echo).
- R7: A second keystroke overwrites an unread code. Only the latest code is readable.
- R8: Reading the receive register does not clear it.
- R9: Reads of the transmit register and of other addresses from 0xFFFFFF08 to 0xFFFFFFFF return 0. Writes to those other addresses emit no character and leave the receive register unchanged.
- R10: Reads are combinational: `rd_data` reflects the address and register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| key_valid | input | 1 | Keystroke strobe |
| key_code | input | 8 | Keystroke code |
| chr_valid | output | 1 | Output character strobe |
| chr_data | output | 8 | Output character code |
| kbd_irq | output | 1 | Keystroke interrupt pulse |

## Verification
Every registered result is due exactly one cycle after its stimulus edge. That covers the character strobe and data, the irq pulse, and the receive register seen through a read. Read data itself is due in the same cycle as its address. The bench keeps a behavioural model that takes the same inputs at each rising edge and produces its expected outputs for the next cycle. It then compares every output at the falling edge, with the read address already applied, so each result is sampled in the cycle it is due.

// File: rtl/term_port.sv
module term_port #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CW        = 8,
  parameter logic [AW-1:0] BASE    = 32'hFFFF_FF00,
  parameter int          WIN_BITS  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          key_valid,
  input  logic [CW-1:0] key_code,
  output logic          chr_valid,
  output logic [CW-1:0] chr_data,
  output logic          kbd_irq
);
  localparam int OFF_TX = 0;
  localparam int OFF_RX = 1;

  logic          in_win;
  logic [WIN_BITS-3:0] word_sel;
  logic          hit_tx, hit_rx;
  logic [CW-1:0] rx_q;

  assign in_win   = bus_addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS];
  assign word_sel = bus_addr[WIN_BITS-1:2];
  assign hit_tx   = in_win && word_sel == OFF_TX;
  assign hit_rx   = in_win && word_sel == OFF_RX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_valid <= 1'b0;
      chr_data  <= '0;
      kbd_irq   <= 1'b0;
      rx_q      <= '0;
    end else begin
      chr_valid <= bus_we && hit_tx;
      if (bus_we && hit_tx) chr_data <= bus_wdata[CW-1:0];
      kbd_irq   <= key_valid;
      if (key_valid) rx_q <= key_code;
    end
  end

  assign bus_rdata = hit_rx ? {{(DW-CW){1'b0}}, rx_q} : '0;

  assert_tx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_tx) |=> (chr_valid && chr_data == $past(bus_wdata[CW-1:0])));
  assert_no_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !(bus_we && hit_tx)) |=> !chr_valid);
  assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> kbd_irq);
  assert_rx_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(rx_q));
  assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_rx |-> bus_rdata == '0);
endmodule

// File: tb/test_term_port.sv
module test_term_port;
  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_we = 0, key_valid = 0, chr_valid, kbd_irq;
  logic [7:0] key_code = 0, chr_data;
  int compared = 0, mismatched = 0;
  bit done = 0;

  // model state
  bit m_cv = 0, m_irq = 0;
  logic [7:0] m_cd = 0, m_rx = 0;

  term_port i_term_port (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .key_valid, .key_code, .chr_valid, .chr_data, .kbd_irq);

  always #2 clk = ~clk;

  function automatic logic [31:0] m_read(logic [31:0] a);
    if (a >= 32'hFFFF_FF04 && a <= 32'hFFFF_FF07) return {24'h0, m_rx};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_cv <= 0; m_cd <= 0; m_irq <= 0; m_rx <= 0; end
    else begin
      m_cv <= bus_we && bus_addr >= 32'hFFFF_FF00 && bus_addr <= 32'hFFFF_FF03;
      if (bus_we && bus_addr >= 32'hFFFF_FF00 && bus_addr <= 32'hFFFF_FF03) m_cd <= bus_wdata[7:0];
      m_irq <= key_valid;
      if (key_valid) m_rx <= key_code;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10: continuous comparison each cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R6 chr_valid", chr_valid, m_cv);
    if (m_cv) chk("R2/R3 chr_data", chr_data, m_cd);
    chk("R5 kbd_irq", kbd_irq, m_irq);
    chk("R4/R7/R8/R9/R10 rdata", bus_rdata, m_read(bus_addr));
  end

  task automatic cyc(logic [31:0] a, bit we, logic [31:0] d, bit kv, logic [7:0] kc);
    @(negedge clk); #1;
    bus_addr = a; bus_we = we; bus_wdata = d; key_valid = kv; key_code = kc;
  endtask

  initial begin
    #20000;
    mismatched++; $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    bus_addr = 32'hFFFF_FF04; #0.5;
    chk("R1 reset rdata", bus_rdata, 0);
    chk("R1 reset chr_valid", chr_valid, 0);
    chk("R1 reset kbd_irq", kbd_irq, 0);
    cyc(32'hFFFF_FF00, 1, 32'h0000_0041, 0, 0);   // R2
    cyc(32'hFFFF_FF03, 1, 32'hDEAD_BE42, 0, 0);   // R3 upper bits ignored, any byte addr
    cyc(32'hFFFF_FF01, 1, 32'h1234_5643, 0, 0);   // R2 back-to-back
    cyc(32'hFFFF_FF04, 0, 0, 1, 8'h61);           // R4 R5 R6
    cyc(32'hFFFF_FF04, 0, 0, 0, 0);
    cyc(32'hFFFF_FF07, 0, 0, 0, 0);               // R8 reads persist
    cyc(32'hFFFF_FF05, 0, 0, 1, 8'h62);           // R7
    cyc(32'hFFFF_FF06, 0, 0, 1, 8'hF3);           // R5 back-to-back, R7 overwrite
    cyc(32'hFFFF_FF04, 0, 0, 0, 0);
    cyc(32'hFFFF_FF00, 0, 0, 0, 0);               // R9 tx reads zero
    cyc(32'hFFFF_FF10, 1, 32'h55, 0, 0);          // R9 other address write ignored
    cyc(32'hFFFF_FFFC, 1, 32'h66, 0, 0);
    cyc(32'hFFFF_FF08, 0, 0, 0, 0);
    cyc(32'hFFFF_FF04, 1, 32'h77, 0, 0);          // R9 write to rx ignored
    cyc(32'hFFFF_FF04, 0, 0, 0, 0);
    cyc(32'hFFFF_FF00, 1, 32'hFFFF_FF0A, 1, 8'h7A); // R6 simultaneous
    cyc(32'hFFFF_FF04, 0, 0, 0, 0);               // R10
    cyc(32'hFFFF_FF00, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule